// File: doc/BRIEF.md
# FIFO Watermark Interrupt Controller

This block turns the fill state of a transmit queue and a receive queue into one interrupt line. It takes the two occupancy counts and the two traffic strobes (a pop from the transmit side, a push into the receive side). From them it derives six condition flags. Two flags are events: a push into a full receive queue and a pop from an empty transmit queue. These stay set until software clears them. The other four flags are levels: transmit occupancy below its watermark, transmit queue full, receive occupancy at or above its watermark, and receive queue full. Each level flag is latched while its condition holds.

Software reaches the block through a simple register port with a write strobe, a byte address and a combinational read. It reads the latched flags and clears them by writing ones. It widens the interrupt mask through a set-only register and narrows it through a clear-only register, and it reads the resulting mask back from a separate location. The interrupt line is high whenever a latched flag and its mask bit are both set. Setting the transmit watermark to 1 turns the below-watermark flag into a transmit-empty indication.

Top module: `fifo_wm_irq`

## Requirements
- R1: While reset is held, the flag register reads 0, the mask reads 0, the transmit watermark reads 1, the receive watermark reads 32 and irq is 0.
- R2: Register byte offsets are: flags 0x04 (read, write-one-to-clear), mask set 0x08 (write only, reads 0), mask clear 0x0C (write only, reads 0), mask 0x10 (read only), transmit watermark 0x28, receive watermark 0x2C. Any other offset reads 0. Flags and mask share one layout: bit 0 receive overflow, bit 2 transmit below watermark, bit 3 transmit full, bit 4 receive at/above watermark, bit 5 receive full, bit 6 transmit underflow. Bits 1 and 7 to 31 read 0.
- R3: A receive push while the receive count equals the depth (63) sets bit 0 one clock later. A push at count 62 does not set it. The bit stays set until a write of 1 to it. When a push event and that clearing write fall in the same cycle, the bit stays set.
- R4: A transmit pop while the transmit count is 0 sets bit 6 one clock later. A pop at count 1 does not set it. The bit is sticky and cleared by a write of 1, with the event taking precedence over a simultaneous clear.
- R5: Bit 2 is set one clock after a cycle in which the transmit count is below the transmit watermark. A watermark of 0 never sets it.
- R6: Bit 3 is set after a cycle with the transmit count equal to 63. Bit 5 is set after a cycle with the receive count equal to 63. Bit 4 is set after a cycle with the receive count at or above the receive watermark.
- R7: Level bits (2 to 5) stay latched after their condition ends, until a write of 1 clears them. If a clearing write and the condition fall in the same cycle, the clear wins. The bit then reads 0 for one cycle and sets again on the next clock while the condition holds. Writing 0 bits to the flag register changes nothing.
- R8: A write to the mask-set offset ORs the written bits into the mask. A write to the mask-clear offset clears the written bits. Zero bits have no effect, and a write to the mask read-back offset changes nothing.
- R9: irq is 1 exactly when some flag bit and the same mask bit are both 1. It follows the registered flags and mask in the same cycle they change.
- R10: The watermark registers keep only the low 6 bits of a write and read back that value, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset for read and write |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr (combinational) |
| txLevel | input | 6 | Transmit queue occupancy |
| rxLevel | input | 6 | Receive queue occupancy |
| txPop | input | 1 | Transmit queue read strobe |
| rxPush | input | 1 | Receive queue write strobe |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same flag in the same cycle: software's write-one-to-clear and the hardware setting the flag. The bench provokes this on purpose. It raises a receive push into a full queue in the cycle of a clearing write to bit 0, and expects the bit to survive. For the level flags it holds the condition through a clearing write. It then expects the bit to read 0 right after that write's clock edge and 1 one edge later. The watermark sweeps depend on the same collision, because each point clears all flags while the new occupancy is applied.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned IRQ_N  = 7;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BUS_AW-1:0] OFS_FLAGS   = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_MASKSET = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_MASKCLR = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_MASK    = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_TXWM    = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_RXWM    = 8'h2C;

  localparam int unsigned BIT_RXOVF   = 0;
  localparam int unsigned BIT_TXLOW   = 2;
  localparam int unsigned BIT_TXFULL  = 3;
  localparam int unsigned BIT_RXAVAIL = 4;
  localparam int unsigned BIT_RXFULL  = 5;
  localparam int unsigned BIT_TXUDF   = 6;

  localparam logic [IRQ_N-1:0] IMPL_BITS   = 7'b1111101;
  localparam logic [IRQ_N-1:0] STICKY_BITS = 7'b1000001;

  typedef struct packed {
    logic              clrFlags;
    logic              setMask;
    logic              clrMask;
    logic              ldTxWm;
    logic              ldRxWm;
    logic [BYTE_W-1:0] wdata;
  } regStrobe_t;
endpackage

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [BUS_DW-1:0] busWdata,
  input  logic [IRQ_N-1:0]  flagsQ,
  input  logic [IRQ_N-1:0]  maskQ,
  input  logic [LVL_W-1:0]  txWmQ,
  input  logic [LVL_W-1:0]  rxWmQ,
  output regStrobe_t        strobe,
  output logic [BUS_DW-1:0] busRdata
);
  logic unusedHi;
  assign unusedHi = ^busWdata[BUS_DW-1:BYTE_W];

  always_comb begin
    strobe          = '0;
    strobe.wdata    = busWdata[BYTE_W-1:0];
    strobe.clrFlags = busWr && (busAddr == OFS_FLAGS);
    strobe.setMask  = busWr && (busAddr == OFS_MASKSET);
    strobe.clrMask  = busWr && (busAddr == OFS_MASKCLR);
    strobe.ldTxWm   = busWr && (busAddr == OFS_TXWM);
    strobe.ldRxWm   = busWr && (busAddr == OFS_RXWM);
  end

  always_comb begin
    unique case (busAddr)
      OFS_FLAGS: busRdata = BUS_DW'(flagsQ);
      OFS_MASK:  busRdata = BUS_DW'(maskQ);
      OFS_TXWM:  busRdata = BUS_DW'(txWmQ);
      OFS_RXWM:  busRdata = BUS_DW'(rxWmQ);
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/fifo_irq_datapath.sv
module fifo_irq_datapath
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH     = 63,
  parameter int unsigned TX_WM_RST = 1,
  parameter int unsigned RX_WM_RST = 32,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             txPop,
  input  logic             rxPush,
  output logic [IRQ_N-1:0] flagsQ,
  output logic [IRQ_N-1:0] maskQ,
  output logic [LVL_W-1:0] txWmQ,
  output logic [LVL_W-1:0] rxWmQ,
  output logic             irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [IRQ_N-1:0] setVec;
  logic [IRQ_N-1:0] clrVec;
  logic [IRQ_N-1:0] flagsNext;
  logic             unusedWd;

  assign unusedWd = ^strobe.wdata;
  assign clrVec   = strobe.clrFlags ? strobe.wdata[IRQ_N-1:0] : '0;

  always_comb begin
    setVec              = '0;
    setVec[BIT_RXOVF]   = rxPush && (rxLevel == FULL_LVL);
    setVec[BIT_TXLOW]   = txLevel < txWmQ;
    setVec[BIT_TXFULL]  = txLevel == FULL_LVL;
    setVec[BIT_RXAVAIL] = rxLevel >= rxWmQ;
    setVec[BIT_RXFULL]  = rxLevel == FULL_LVL;
    setVec[BIT_TXUDF]   = txPop && (txLevel == '0);
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    if (!IMPL_BITS[i]) begin : g_absent
      assign flagsNext[i] = 1'b0;
    end else if (STICKY_BITS[i]) begin : g_event
      assign flagsNext[i] = setVec[i] | (flagsQ[i] & ~clrVec[i]);
    end else begin : g_level
      assign flagsNext[i] = (setVec[i] | flagsQ[i]) & ~clrVec[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      maskQ  <= '0;
      txWmQ  <= LVL_W'(TX_WM_RST);
      rxWmQ  <= LVL_W'(RX_WM_RST);
    end else begin
      flagsQ <= flagsNext;
      if (strobe.setMask)
        maskQ <= (maskQ | strobe.wdata[IRQ_N-1:0]) & IMPL_BITS;
      else if (strobe.clrMask)
        maskQ <= maskQ & ~strobe.wdata[IRQ_N-1:0];
      if (strobe.ldTxWm) txWmQ <= strobe.wdata[LVL_W-1:0];
      if (strobe.ldRxWm) rxWmQ <= strobe.wdata[LVL_W-1:0];
    end
  end

  assign irq = |(flagsQ & maskQ);

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxLevel == FULL_LVL) |=> flagsQ[BIT_RXOVF]);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ[BIT_RXOVF] && !(strobe.clrFlags && strobe.wdata[BIT_RXOVF]))
      |=> flagsQ[BIT_RXOVF]);
  assert_udf_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && txLevel == '0) |=> flagsQ[BIT_TXUDF]);
  assert_txlow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel < txWmQ && !(strobe.clrFlags && strobe.wdata[BIT_TXLOW]))
      |=> flagsQ[BIT_TXLOW]);
  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setMask |=> ((maskQ & $past(strobe.wdata[IRQ_N-1:0] & IMPL_BITS))
      == $past(strobe.wdata[IRQ_N-1:0] & IMPL_BITS)));
  assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrMask |=> ((maskQ & $past(strobe.wdata[IRQ_N-1:0])) == '0));
endmodule

// File: rtl/fifo_wm_irq.sv
module fifo_wm_irq
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH     = 63,
  parameter int unsigned TX_WM_RST = 1,
  parameter int unsigned RX_WM_RST = 32,
  localparam int unsigned LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [BUS_DW-1:0] busWdata,
  output logic [BUS_DW-1:0] busRdata,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              txPop,
  input  logic              rxPush,
  output logic              irq
);
  regStrobe_t       strobe;
  logic [IRQ_N-1:0] flagsQ;
  logic [IRQ_N-1:0] maskQ;
  logic [LVL_W-1:0] txWmQ;
  logic [LVL_W-1:0] rxWmQ;

  fifo_irq_ctrl #(.LVL_W(LVL_W)) ctrl_i (
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .flagsQ(flagsQ), .maskQ(maskQ), .txWmQ(txWmQ), .rxWmQ(rxWmQ),
    .strobe(strobe), .busRdata(busRdata)
  );

  fifo_irq_datapath #(.DEPTH(DEPTH), .TX_WM_RST(TX_WM_RST),
                      .RX_WM_RST(RX_WM_RST)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txLevel(txLevel), .rxLevel(rxLevel), .txPop(txPop), .rxPush(rxPush),
    .flagsQ(flagsQ), .maskQ(maskQ), .txWmQ(txWmQ), .rxWmQ(rxWmQ), .irq(irq)
  );
endmodule

// File: tb/fifo_wm_irq_tb.sv
module fifo_wm_irq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [5:0]  txLevel = '0;
  logic [5:0]  rxLevel = '0;
  logic        txPop = 1'b0;
  logic        rxPush = 1'b0;
  logic        irq;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  fifo_wm_irq dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txLevel(txLevel),
    .rxLevel(rxLevel), .txPop(txPop), .rxPush(rxPush), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [31:0] levelFlags(int tl, int rl, int twm, int rwm);
    logic [31:0] e = '0;
    e[2] = tl < twm;
    e[3] = tl == 63;
    e[4] = rl >= rwm;
    e[5] = rl == 63;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired (R1..R10 incomplete)");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int twmList[4] = '{0, 1, 17, 63};
    int rwmList[4] = '{0, 32, 1, 63};

    // R1: values visible while reset is held
    #1;
    rd(8'h04, v); check("R1 flags", v, 32'h0);
    rd(8'h10, v); check("R1 mask", v, 32'h0);
    rd(8'h28, v); check("R1 txWm", v, 32'd1);
    rd(8'h2C, v); check("R1 rxWm", v, 32'd32);
    check("R1 irq", {31'b0, irq}, 32'h0);
    tick();
    rstN = 1'b1;
    tick();

    // R10: watermark width
    wr(8'h28, 32'hFFFF_FFC5); rd(8'h28, v); check("R10 txWm", v, 32'h05);
    wr(8'h2C, 32'h0000_007F); rd(8'h2C, v); check("R10 rxWm", v, 32'h3F);

    // R5/R6: watermark sweeps, every point cleared as the levels change
    for (int w = 0; w < 4; w++) begin
      wr(8'h28, twmList[w]);
      wr(8'h2C, rwmList[w]);
      for (int l = 0; l < 64; l++) begin
        txLevel = 6'(l);
        rxLevel = 6'(63 - l);
        wr(8'h04, 32'h7F);
        tick();
        rd(8'h04, v);
        check("R5/R6 sweep", v, levelFlags(l, 63 - l, twmList[w], rwmList[w]));
      end
    end

    // R7: level latching and clear/condition collision
    wr(8'h28, 32'd10); wr(8'h2C, 32'd32);
    txLevel = 6'd5; rxLevel = 6'd0;
    tick();
    rd(8'h04, v); check("R7 set", v & 32'h4, 32'h4);
    txLevel = 6'd20;
    tick(); tick();
    rd(8'h04, v); check("R7 latched after condition ends", v & 32'h4, 32'h4);
    wr(8'h04, 32'h0);
    rd(8'h04, v); check("R7 zero write no effect", v & 32'h4, 32'h4);
    wr(8'h04, 32'h4);
    tick();
    rd(8'h04, v); check("R7 cleared stays clear", v & 32'h4, 32'h0);
    txLevel = 6'd5;
    tick();
    wr(8'h04, 32'h4);
    rd(8'h04, v); check("R7 clear wins in collision cycle", v & 32'h4, 32'h0);
    tick();
    rd(8'h04, v); check("R7 re-asserts next cycle", v & 32'h4, 32'h4);

    // R3: receive overflow
    txLevel = 6'd10; wr(8'h28, 32'd1);
    rxLevel = 6'd63;
    wr(8'h04, 32'h7F);
    rd(8'h04, v); check("R3 cleared", v & 32'h1, 32'h0);
    rxPush = 1'b1; tick(); rxPush = 1'b0;
    rd(8'h04, v); check("R3 set by push at full", v & 32'h1, 32'h1);
    tick(); tick();
    rd(8'h04, v); check("R3 sticky", v & 32'h1, 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); check("R3 w1c", v & 32'h1, 32'h0);
    rxPush = 1'b1; wr(8'h04, 32'h1); rxPush = 1'b0;
    rd(8'h04, v); check("R3 event beats clear", v & 32'h1, 32'h1);
    wr(8'h04, 32'h1);
    rxLevel = 6'd62;
    rxPush = 1'b1; tick(); rxPush = 1'b0;
    rd(8'h04, v); check("R3 no set at 62", v & 32'h1, 32'h0);

    // R4: transmit underflow
    txLevel = 6'd0;
    wr(8'h04, 32'h7F);
    txPop = 1'b1; tick(); txPop = 1'b0;
    rd(8'h04, v); check("R4 set by pop at empty", v & 32'h40, 32'h40);
    tick();
    rd(8'h04, v); check("R4 sticky", v & 32'h40, 32'h40);
    txPop = 1'b1; wr(8'h04, 32'h40); txPop = 1'b0;
    rd(8'h04, v); check("R4 event beats clear", v & 32'h40, 32'h40);
    wr(8'h04, 32'h40);
    rd(8'h04, v); check("R4 w1c", v & 32'h40, 32'h0);
    txLevel = 6'd1;
    txPop = 1'b1; tick(); txPop = 1'b0;
    rd(8'h04, v); check("R4 no set at 1", v & 32'h40, 32'h0);

    // R8/R2: mask set/clear registers
    wr(8'h08, 32'h05); rd(8'h10, v); check("R8 enable", v, 32'h05);
    wr(8'h08, 32'h50); rd(8'h10, v); check("R8 enable or", v, 32'h55);
    wr(8'h0C, 32'h04); rd(8'h10, v); check("R8 disable", v, 32'h51);
    wr(8'h08, 32'hFF); rd(8'h10, v); check("R8/R2 unimplemented bits", v, 32'h7D);
    wr(8'h10, 32'h0);  rd(8'h10, v); check("R8 mask read-only", v, 32'h7D);
    rd(8'h08, v); check("R2 set reg reads 0", v, 32'h0);
    rd(8'h0C, v); check("R2 clear reg reads 0", v, 32'h0);
    rd(8'h00, v); check("R2 unmapped reads 0", v, 32'h0);

    // R9: interrupt line
    txLevel = 6'd10; rxLevel = 6'd0;
    wr(8'h28, 32'd1); wr(8'h2C, 32'd32);
    wr(8'h04, 32'h7F);
    rd(8'h04, v); check("R9 flags idle", v, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    wr(8'h28, 32'd20);
    tick();
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h04);
    check("R9 irq low after disable", {31'b0, irq}, 32'h0);
    rd(8'h04, v); check("R9 flag still set", v, 32'h4);
    wr(8'h08, 32'h04);
    check("R9 irq on re-enable", {31'b0, irq}, 32'h1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule